// File: doc/BRIEF.md
# Saturating DSP Arithmetic Unit

This unit is a small arithmetic helper for a DSP datapath. A 4-bit operation code selects one of several clamping or rounding functions applied to 64-bit operands. Results are combinational and appear in the same cycle as the inputs. A single registered status bit records that some clamp has happened since it was last cleared.

The status bit is held by a two-state machine with the states `FLAG_IDLE` (bit low) and `FLAG_STICKY` (bit high). The transition `IDLE_TO_STICKY` is taken on any clamp event. The transition `STICKY_TO_IDLE` is taken when `ovf_clr` is high in a cycle that has no clamp event. Every other case holds the current state. Synchronous reset forces `FLAG_IDLE`.

The width or shift argument `amt` is used only by the clip and boundary-rounding operations. Signed values are two's complement.

Top module: `sdsp_unit`

## Requirements
- R1: Codes 1, 2 and 3 saturate `a_in` as a signed value to 8, 16 and 32 bits. A value that survives sign-extension of its low N bits passes unchanged. Otherwise a negative input gives -(2^(N-1)) and a non-negative input gives 2^(N-1)-1, both sign-extended to 64 bits.
- R2: Codes 4, 5 and 6 saturate `a_in` as an unsigned value to 8, 16 and 32 bits. A value whose bits above N are all zero passes unchanged. Otherwise a negative input (bit 63 set) gives 0 and any other input gives 2^N-1.
- R3: Code 7 adds `a_in` and `b_in` modulo 2^64. When the operands' signs differ, or the sum keeps the operands' sign, the sum is the result. If the sum's sign flips to negative, the result is 0x7FFFFFFFFFFFFFFF. If it flips to positive, the result is 0x8000000000000000.
- R4: Code 8 clamps signed `a_in` to the range -(2^U) to 2^U-1, where U is `amt`. With U=63 every value fits.
- R5: Code 9 adds 1 to `a_in` when its two lowest bits are both 1 and otherwise passes it unchanged.
- R6: Code 10 with N=`amt` passes `a_in` unchanged when N is 0. Otherwise it sign-extends the low 32 bits of `a_in` and adds 2^(N-1), modulo 2^64.
- R7: Code 11 returns (a_in+1) shifted right arithmetically by one. The sum is formed with one extra bit, so the most positive input gives 0x4000000000000000.
- R8: A clamp in R1, R2, R3 or R4 sets `ovf_sticky` at the next clock edge. A value that is in range leaves the flag unchanged.
- R9: Once set, `ovf_sticky` stays high until `ovf_clr` is sampled high. A clamp in the same cycle as `ovf_clr` keeps the flag set.
- R10: Codes 0, 12, 13, 14 and 15 return `a_in` and do not change the flag.
- R11: While `rst_n` is low at a clock edge, `ovf_sticky` becomes 0, even if it was set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_code | input | 4 | Operation select |
| a_in | input | 64 | First operand |
| b_in | input | 64 | Second operand (saturating add only) |
| amt | input | 6 | Clip exponent U or rounding position N |
| ovf_clr | input | 1 | Clear strobe for the sticky flag |
| result | output | 64 | Combinational result |
| ovf_sticky | output | 1 | Sticky overflow status |

## Verification
Each saturating width is tried with values just inside and just outside both limits, and with large negative values. This separates a range decision that is off by one from a wrong clamp polarity. The add is tried with mixed signs at the extremes and with same-sign pairs that do and do not wrap, which separates the two overflow directions from a legal sum. Clip and boundary rounding are swept over small and extreme `amt` values, including 0 and 63. The flag is driven through set, hold, clear, a set in the same cycle as a clear, and a reset while set, so each state transition is taken.

// File: rtl/sdsp_pkg.sv
package sdsp_pkg;
    typedef enum logic [3:0] {
        OP_PASS   = 4'd0,
        OP_SSAT8  = 4'd1,
        OP_SSAT16 = 4'd2,
        OP_SSAT32 = 4'd3,
        OP_USAT8  = 4'd4,
        OP_USAT16 = 4'd5,
        OP_USAT32 = 4'd6,
        OP_ADDSAT = 4'd7,
        OP_CLIP   = 4'd8,
        OP_CRND   = 4'd9,
        OP_RNDN   = 4'd10,
        OP_HALF   = 4'd11
    } sdsp_op_e;

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_STICKY = 1'b1
    } flag_state_e;
endpackage

// File: rtl/sdsp_narrow_sat.sv
module sdsp_narrow_sat #(
    parameter int DW     = 64,
    parameter int NB     = 8,
    parameter bit SIGNED = 1'b1
) (
    input  logic [DW-1:0] val,
    output logic [DW-1:0] res,
    output logic          clamp
);
    localparam int UPPER = DW - NB;

    generate
        if (SIGNED) begin : g_signed
            logic          fits;
            logic [DW-1:0] lim_lo;
            logic [DW-1:0] lim_hi;
            assign fits   = (val == {{UPPER{val[NB-1]}}, val[NB-1:0]});
            assign lim_lo = {{(UPPER+1){1'b1}}, {(NB-1){1'b0}}};
            assign lim_hi = {{(UPPER+1){1'b0}}, {(NB-1){1'b1}}};
            assign clamp  = !fits;
            assign res    = fits ? val : (val[DW-1] ? lim_lo : lim_hi);
        end else begin : g_unsigned
            logic          fits;
            logic [DW-1:0] lim_hi;
            assign fits   = (val[DW-1:NB] == '0);
            assign lim_hi = {{UPPER{1'b0}}, {NB{1'b1}}};
            assign clamp  = !fits;
            assign res    = fits ? val : (val[DW-1] ? '0 : lim_hi);
        end
    endgenerate
endmodule

// File: rtl/sdsp_addsat.sv
module sdsp_addsat #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] res,
    output logic          clamp
);
    localparam logic [DW-1:0] POS_MAX = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0] NEG_MIN = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] sum;
    assign sum   = x + y;
    assign clamp = (x[DW-1] == y[DW-1]) && (sum[DW-1] != x[DW-1]);
    assign res   = !clamp ? sum : (sum[DW-1] ? POS_MAX : NEG_MIN);
endmodule

// File: rtl/sdsp_round_clip.sv
module sdsp_round_clip #(
    parameter int DW = 64,
    parameter int AW = 6
) (
    input  logic [DW-1:0] val,
    input  logic [AW-1:0] amt,
    output logic [DW-1:0] clip_res,
    output logic          clip_hit,
    output logic [DW-1:0] crnd_res,
    output logic [DW-1:0] rndn_res,
    output logic [DW-1:0] half_res
);
    localparam int HW = DW / 2;
    localparam int EW = DW + 2;

    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] lim;
    logic signed [EW-1:0] top_v;
    logic signed [EW-1:0] bot_v;
    logic        [DW:0]   half_sum;
    logic        [DW-1:0] low_ext;

    assign ext   = {{2{val[DW-1]}}, val};
    assign lim   = {{(EW-1){1'b0}}, 1'b1} <<< amt;
    assign top_v = lim - 1;
    assign bot_v = -lim;

    always_comb begin
        clip_hit = 1'b1;
        if (ext > top_v) begin
            clip_res = top_v[DW-1:0];
        end else if (ext < bot_v) begin
            clip_res = bot_v[DW-1:0];
        end else begin
            clip_res = val;
            clip_hit = 1'b0;
        end
    end

    assign crnd_res = (val[1:0] == 2'b11) ? val + 1'b1 : val;

    assign low_ext  = {{HW{val[HW-1]}}, val[HW-1:0]};
    assign rndn_res = (amt == '0) ? val
                    : low_ext + ({{(DW-1){1'b0}}, 1'b1} << (amt - 1'b1));

    assign half_sum = {val[DW-1], val} + {{DW{1'b0}}, 1'b1};
    assign half_res = half_sum[DW:1];
endmodule

// File: rtl/sdsp_flag_fsm.sv
module sdsp_flag_fsm
    import sdsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (set_evt)         state_d = FLAG_STICKY;
            FLAG_STICKY: if (clr && !set_evt) state_d = FLAG_IDLE;
            default:                          state_d = FLAG_IDLE;
        endcase
    end

    always_comb begin
        flag = (state_q == FLAG_STICKY);
    end
endmodule

// File: rtl/sdsp_unit.sv
module sdsp_unit
    import sdsp_pkg::*;
#(
    parameter int DW      = 64,
    parameter int AW      = 6,
    parameter int LANES   = 3,
    parameter int BASE_W  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [3:0]    op_code,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    input  logic [AW-1:0] amt,
    input  logic          ovf_clr,
    output logic [DW-1:0] result,
    output logic          ovf_sticky
);
    logic [DW-1:0] s_res [LANES];
    logic [DW-1:0] u_res [LANES];
    logic [LANES-1:0] s_hit;
    logic [LANES-1:0] u_hit;

    for (genvar gi = 0; gi < LANES; gi++) begin : g_lane
        localparam int NB = BASE_W << gi;
        sdsp_narrow_sat #(.DW(DW), .NB(NB), .SIGNED(1'b1)) u_ssat (
            .val(a_in), .res(s_res[gi]), .clamp(s_hit[gi]));
        sdsp_narrow_sat #(.DW(DW), .NB(NB), .SIGNED(1'b0)) u_usat (
            .val(a_in), .res(u_res[gi]), .clamp(u_hit[gi]));
    end

    logic [DW-1:0] add_res;
    logic          add_hit;
    sdsp_addsat #(.DW(DW)) u_add (
        .x(a_in), .y(b_in), .res(add_res), .clamp(add_hit));

    logic [DW-1:0] clip_res, crnd_res, rndn_res, half_res;
    logic          clip_hit;
    sdsp_round_clip #(.DW(DW), .AW(AW)) u_rc (
        .val(a_in), .amt(amt),
        .clip_res(clip_res), .clip_hit(clip_hit),
        .crnd_res(crnd_res), .rndn_res(rndn_res), .half_res(half_res));

    logic sat_hit;

    always_comb begin
        result  = a_in;
        sat_hit = 1'b0;
        case (op_code)
            OP_SSAT8:  begin result = s_res[0]; sat_hit = s_hit[0]; end
            OP_SSAT16: begin result = s_res[1]; sat_hit = s_hit[1]; end
            OP_SSAT32: begin result = s_res[2]; sat_hit = s_hit[2]; end
            OP_USAT8:  begin result = u_res[0]; sat_hit = u_hit[0]; end
            OP_USAT16: begin result = u_res[1]; sat_hit = u_hit[1]; end
            OP_USAT32: begin result = u_res[2]; sat_hit = u_hit[2]; end
            OP_ADDSAT: begin result = add_res;  sat_hit = add_hit;  end
            OP_CLIP:   begin result = clip_res; sat_hit = clip_hit; end
            OP_CRND:   result = crnd_res;
            OP_RNDN:   result = rndn_res;
            OP_HALF:   result = half_res;
            default:   result = a_in;
        endcase
    end

    sdsp_flag_fsm u_flag (
        .clk(clk), .rst_n(rst_n), .set_evt(sat_hit),
        .clr(ovf_clr), .flag(ovf_sticky));
endmodule

// File: rtl/sdsp_unit_chk.sv
module sdsp_unit_chk #(
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst_n,
    input logic [3:0]    op_code,
    input logic [DW-1:0] a_in,
    input logic [DW-1:0] b_in,
    input logic          ovf_clr,
    input logic [DW-1:0] result,
    input logic          ovf_sticky,
    input logic          sat_hit
);
    assert_hit_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sat_hit |=> ovf_sticky);

    assert_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_sticky) |-> $past(sat_hit));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_sticky && !ovf_clr) |=> ovf_sticky);

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !sat_hit) |=> !ovf_sticky);

    assert_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd0 || op_code >= 4'd12) |-> (result == a_in && !sat_hit));

    assert_ssat8_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd1) |-> (result == {{(DW-8){result[7]}}, result[7:0]}));

    assert_usat8_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd4) |-> (result[DW-1:8] == '0));

    assert_mixed_add_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code == 4'd7 && a_in[DW-1] != b_in[DW-1]) |-> (result == a_in + b_in));
endmodule

bind sdsp_unit sdsp_unit_chk #(.DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .a_in(a_in), .b_in(b_in),
    .ovf_clr(ovf_clr), .result(result), .ovf_sticky(ovf_sticky), .sat_hit(sat_hit));

// File: tb/sdsp_unit_tb_top.sv
module sdsp_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_code = '0;
    logic [63:0] a_in = '0;
    logic [63:0] b_in = '0;
    logic [5:0]  amt = '0;
    logic        ovf_clr = 1'b0;
    logic [63:0] result;
    logic        ovf_sticky;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic model_flag = 1'b0;

    typedef struct {
        logic [63:0] res;
        logic        flg;
        string       tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2 clk = ~clk;

    sdsp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_code(op_code), .a_in(a_in), .b_in(b_in),
        .amt(amt), .ovf_clr(ovf_clr), .result(result), .ovf_sticky(ovf_sticky));

    function automatic logic [64:0] ref_op(input logic [3:0] o, input logic [63:0] a,
                                           input logic [63:0] b, input logic [5:0] n);
        longint sa;
        longint lo;
        longint hi;
        int w;
        logic signed [64:0] s65;
        logic signed [65:0] x66;
        logic signed [65:0] l66;
        logic [64:0] h65;
        sa = $signed(a);
        case (o)
            4'd1, 4'd2, 4'd3: begin
                w  = 8 << (o - 1);
                lo = -(longint'(1) <<< (w - 1));
                hi = (longint'(1) <<< (w - 1)) - 1;
                if (sa < lo)      return {1'b1, 64'(lo)};
                else if (sa > hi) return {1'b1, 64'(hi)};
                else              return {1'b0, a};
            end
            4'd4, 4'd5, 4'd6: begin
                w = 8 << (o - 4);
                if (sa < 0)                       return {1'b1, 64'd0};
                else if (a > (64'd1 << w) - 1)    return {1'b1, (64'd1 << w) - 1};
                else                              return {1'b0, a};
            end
            4'd7: begin
                s65 = $signed({a[63], a}) + $signed({b[63], b});
                if (s65 > 65'sh0_7FFF_FFFF_FFFF_FFFF)       return {1'b1, 64'h7FFF_FFFF_FFFF_FFFF};
                else if (s65 < -65'sh0_8000_0000_0000_0000) return {1'b1, 64'h8000_0000_0000_0000};
                else                                        return {1'b0, s65[63:0]};
            end
            4'd8: begin
                x66 = $signed({{2{a[63]}}, a});
                l66 = 66'sd1 <<< n;
                if (x66 > l66 - 1)  return {1'b1, 64'(l66 - 1)};
                else if (x66 < -l66) return {1'b1, 64'(-l66)};
                else                 return {1'b0, a};
            end
            4'd9:  return {1'b0, (a[1:0] == 2'b11) ? a + 64'd1 : a};
            4'd10: return {1'b0, (n == 0) ? a
                                 : 64'($signed(a[31:0])) + (64'd1 << (n - 1))};
            4'd11: begin
                h65 = {a[63], a} + 65'd1;
                return {1'b0, h65[64:1]};
            end
            default: return {1'b0, a};
        endcase
    endfunction

    task automatic drive(input logic [3:0] o, input logic [63:0] va, input logic [63:0] vb,
                         input logic [5:0] n, input logic c, input string tag);
        logic [64:0] r;
        sb_item_t it;
        @(negedge clk);
        op_code = o; a_in = va; b_in = vb; amt = n; ovf_clr = c;
        r = ref_op(o, va, vb, n);
        if (r[64])  model_flag = 1'b1;
        else if (c) model_flag = 1'b0;
        it.res = r[63:0];
        it.flg = model_flag;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    initial begin : monitor
        sb_item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (result !== it.res) begin
                    errors++;
                    $display("FAIL %s result: got %h expected %h", it.tag, result, it.res);
                end
                checks++;
                if (ovf_sticky !== it.flg) begin
                    errors++;
                    $display("FAIL %s flag: got %b expected %b", it.tag, ovf_sticky, it.flg);
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin : watchdog
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin : stim
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (ovf_sticky !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset flag: got %b expected 0", ovf_sticky);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 signed saturation, edges and beyond
        drive(4'd1, 64'd127, 0, 0, 0, "R1 s8 max fits");
        drive(4'd1, 64'hFFFF_FFFF_FFFF_FF80, 0, 0, 0, "R1 s8 min fits");
        drive(4'd2, 64'hFFFF_FFFF_FFFF_7FFF, 0, 0, 0, "R1 s16 below min");
        drive(4'd1, 64'd1, 0, 0, 1, "R9 clear after clamp");
        drive(4'd3, 64'h0000_0000_8000_0000, 0, 0, 0, "R1 s32 above max");
        drive(4'd0, 64'h1234, 0, 0, 0, "R9 flag holds");
        drive(4'd2, 64'h8000_0000_0000_0000, 0, 0, 1, "R1 R9 s16 clamp with clear");
        drive(4'd3, 64'hFFFF_FFFF_8000_0000, 0, 0, 1, "R9 clear then fit");
        // R2 unsigned
        drive(4'd4, 64'd255, 0, 0, 0, "R2 u8 max fits");
        drive(4'd4, 64'd256, 0, 0, 1, "R2 u8 over with clear");
        drive(4'd5, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 1, "R2 u16 negative");
        drive(4'd6, 64'h0000_0001_0000_0000, 0, 0, 1, "R2 u32 over");
        drive(4'd6, 64'h0000_0000_FFFF_FFFF, 0, 0, 1, "R2 u32 fits R8 no set");
        // R3 saturating add
        drive(4'd7, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 0, 0, "R3 mixed signs");
        drive(4'd7, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, "R3 positive wrap");
        drive(4'd7, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 0, 1, "R3 negative wrap");
        drive(4'd7, 64'd100, 64'd23, 0, 1, "R3 legal sum");
        // R4 clip
        drive(4'd8, 64'd8, 0, 6'd3, 0, "R4 clip above");
        drive(4'd8, 64'hFFFF_FFFF_FFFF_FFF8, 0, 6'd3, 1, "R4 clip at min");
        drive(4'd8, 64'hFFFF_FFFF_FFFF_FFF7, 0, 6'd3, 1, "R4 clip below");
        drive(4'd8, 64'h8000_0000_0000_0000, 0, 6'd63, 1, "R4 clip U63 fits");
        drive(4'd8, 64'd1, 0, 6'd0, 1, "R4 clip U0 at max");
        // R5 R6 R7 rounding
        drive(4'd9, 64'd7, 0, 0, 1, "R5 low bits 11");
        drive(4'd9, 64'd6, 0, 0, 0, "R5 low bits 10");
        drive(4'd10, 64'hDEAD_BEEF_0000_0010, 0, 6'd0, 0, "R6 N zero");
        drive(4'd10, 64'h0000_0001_8000_0000, 0, 6'd4, 0, "R6 sign-extend add");
        drive(4'd10, 64'd5, 0, 6'd63, 0, "R6 N63");
        drive(4'd11, 64'h7FFF_FFFF_FFFF_FFFF, 0, 0, 0, "R7 most positive");
        drive(4'd11, 64'hFFFF_FFFF_FFFF_FFFC, 0, 0, 0, "R7 negative");
        drive(4'd11, 64'd3, 0, 0, 0, "R7 odd");
        // R10 unused codes with flag both ways
        drive(4'd12, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R10 code 12");
        drive(4'd1, 64'd999, 0, 0, 0, "R8 set before unused");
        drive(4'd15, 64'h0123_4567_89AB_CDEF, 0, 0, 0, "R10 code 15 holds flag");
        drive(4'd0, 64'd42, 0, 0, 0, "R10 code 0");
        repeat (2) @(posedge clk);
        // R11 reset while flag set
        @(negedge clk);
        op_code = 4'd0; ovf_clr = 1'b0;
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        checks++;
        if (ovf_sticky !== 1'b0) begin
            errors++;
            $display("FAIL R11 reset while set: got %b expected 0", ovf_sticky);
        end
        @(negedge clk);
        rst_n = 1'b1;
        model_flag = 1'b0;
        drive(4'd13, 64'd9, 0, 0, 0, "R11 R10 after reset");
        repeat (3) @(posedge clk);
        #1;
        finish_run();
    end
endmodule